// File: doc/BRIEF.md
# Interrupt status and enable controller

This block gathers the interrupt conditions of up to seven peripherals of a small 8-bit system into one byte-wide status register. Each peripheral strobes a one-cycle pulse when it has an event, and the matching status flag latches and stays set until software clears it. A second byte-wide register holds one enable bit per source. An active-low request line goes to the processor whenever a latched flag meets a set enable bit.

The flags latch whether or not their source is enabled, so software can poll them for timing without taking an interrupt. The top status bit is a summary. It shows that an enabled event actually raised the request line. Software acknowledges a source by writing a 1 to its status bit. While a flag is still set, its source cannot produce a new request edge, so each event has to be cleared before the next one from that source can interrupt.

Top module: `irq_ctrl`

## Requirements
- R1: While the active-low reset `rst_ni` is asserted, and just after it is released, the status register (offset 9) and the enable register (offset 10) both read 0x00 and `irq_no` is high.
- R2: A one-cycle pulse on `src_i[k]` sets status bit k (k = 0..6) at that clock edge, whatever the value of enable bit k.
- R3: A status bit that is set stays set until a write to offset 9 carries a 1 in that bit position. A write of 0 to that position leaves the bit unchanged.
- R4: If a source pulse and a write-1-to-clear reach the same status bit on the same edge, the bit ends up set.
- R5: The enable register at offset 10 holds bits 0..6, one per source. Bit 7 always reads 0 and writes to it are ignored.
- R6: After each clock edge, `irq_no` is low exactly when some status bit k in 0..6 and enable bit k are both 1. It goes high on the first edge at which no such pair remains, whether the flag was cleared or the enable was dropped.
- R7: Status bit 7 is 1 whenever `irq_no` is low. A write of 1 to bit 7 clears it only when no enabled flag is pending after that edge. Otherwise it stays 1.
- R8: Reads are combinational and have no side effects. Addresses other than 9 and 10 read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (4) | Register offset |
| wr_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| src_i | input | NUM_SRC (7) | Per-source event pulses |
| irq_no | output | 1 | Interrupt request to the processor, active low |

## Verification
Every piece of state in this block can be read back over the bus or seen on `irq_no` in the cycle after the edge that wrote it. A lost or sticky flag, a wrong enable bit or a stale summary therefore shows up at the next read of offset 9 or 10, or as a request line that does not match the enabled pending flags. After every random cycle, the bench reads back both registers and compares `irq_no`, so a fault shows within one cycle of the stimulus that exposes it. Directed cases cover the edges that random traffic seldom hits: a set and a clear on the same edge, the reserved enable bit, and a summary clear while a request is still pending.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef struct packed {
    logic stat_we;
    logic en_we;
  } irq_wsel_t;
endpackage

// File: rtl/irq_bus_dec.sv
module irq_bus_dec
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned NUM_SRC  = 7,
  parameter int unsigned STAT_OFS = 9,
  parameter int unsigned EN_OFS   = 10,
  localparam int unsigned DW      = NUM_SRC + 1
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic [DW-1:0]      stat_i,
  input  logic [NUM_SRC-1:0] en_i,
  output irq_wsel_t          wsel_o,
  output logic [DW-1:0]      rdata_o
);
  logic hit_stat, hit_en;

  assign hit_stat = (addr_i == ADDR_W'(STAT_OFS));
  assign hit_en   = (addr_i == ADDR_W'(EN_OFS));

  assign wsel_o.stat_we = wr_i & hit_stat;
  assign wsel_o.en_we   = wr_i & hit_en;

  always_comb begin
    rdata_o = '0;
    if (hit_stat)    rdata_o = stat_i;
    else if (hit_en) rdata_o = {1'b0, en_i};  // reserved top bit
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned NUM_SRC = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] en_nxt_o
);
  logic [NUM_SRC-1:0] en_q;

  assign en_nxt_o = we_i ? wdata_i : en_q;
  assign en_o     = en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_nxt_o;
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned NUM_SRC = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               sum_clr_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] en_nxt_i,
  output logic [NUM_SRC-1:0] flag_o,
  output logic               sum_o,
  output logic               hit_o
);
  logic [NUM_SRC-1:0] flag_q, flag_d;
  logic               sum_q, sum_d;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
    // set beats clear so no event is dropped
    assign flag_d[k] = set_i[k] | (flag_q[k] & ~clr_i[k]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[k] <= 1'b0;
      else         flag_q[k] <= flag_d[k];
    end
  end

  // summary tracks the request that will be driven after this edge
  assign sum_d = (sum_q & ~sum_clr_i) | (|(flag_d & en_nxt_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= 1'b0;
    else         sum_q <= sum_d;
  end

  assign flag_o = flag_q;
  assign sum_o  = sum_q;
  assign hit_o  = |(flag_q & en_i);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned NUM_SRC  = 7,
  parameter int unsigned STAT_OFS = 9,
  parameter int unsigned EN_OFS   = 10,
  localparam int unsigned DW      = NUM_SRC + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_no
);
  irq_wsel_t          wsel;
  logic [NUM_SRC-1:0] en_q, en_nxt, flag_q, clr;
  logic               sum_q, hit;
  logic [DW-1:0]      stat_q;

  assign clr    = wsel.stat_we ? wdata_i[NUM_SRC-1:0] : '0;
  assign stat_q = {sum_q, flag_q};

  irq_bus_dec #(
    .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .STAT_OFS(STAT_OFS), .EN_OFS(EN_OFS)
  ) u_dec (
    .addr_i (addr_i),
    .wr_i   (wr_i),
    .stat_i (stat_q),
    .en_i   (en_q),
    .wsel_o (wsel),
    .rdata_o(rdata_o)
  );

  irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wsel.en_we),
    .wdata_i (wdata_i[NUM_SRC-1:0]),
    .en_o    (en_q),
    .en_nxt_o(en_nxt)
  );

  irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (src_i),
    .clr_i    (clr),
    .sum_clr_i(wsel.stat_we & wdata_i[DW-1]),
    .en_i     (en_q),
    .en_nxt_i (en_nxt),
    .flag_o   (flag_q),
    .sum_o    (sum_q),
    .hit_o    (hit)
  );

  assign irq_no = ~hit;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned NUM_SRC  = 7,
  parameter int unsigned EN_OFS   = 10,
  localparam int unsigned DW      = NUM_SRC + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               wr_i,
  input logic [DW-1:0]      rdata_o,
  input logic [NUM_SRC-1:0] src_i,
  input logic               irq_no,
  input logic [DW-1:0]      stat_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic               stat_we
);
  AST_SRC_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i != '0) |=> ((stat_q[NUM_SRC-1:0] & $past(src_i)) == $past(src_i))); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_we |=> (($past(stat_q[NUM_SRC-1:0]) & ~stat_q[NUM_SRC-1:0]) == '0)); // R3

  AST_EN_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(EN_OFS)) |-> !rdata_o[DW-1]); // R5

  AST_SUM_ON_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> stat_q[DW-1]); // R7

  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == ADDR_W'(EN_OFS)) |=> $stable(en_q)); // R8
endmodule

bind irq_ctrl irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .EN_OFS(EN_OFS)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .wr_i   (wr_i),
  .rdata_o(rdata_o),
  .src_i  (src_i),
  .irq_no (irq_no),
  .stat_q (stat_q),
  .en_q   (en_q),
  .stat_we(wsel.stat_we)
);

// File: tb/sim_irq_ctrl.sv
`timescale 1ns/1ps
module sim_irq_ctrl;
  localparam int CLK_NS = 20;
  localparam int AW = 4;
  localparam int NS = 7;
  localparam logic [AW-1:0] A_STAT = 4'd9;
  localparam logic [AW-1:0] A_EN   = 4'd10;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          wr_i = 1'b0;
  logic [7:0]    wdata_i = '0;
  logic [7:0]    rdata_o;
  logic [NS-1:0] src_i = '0;
  logic          irq_no;

  int n_chk = 0;
  int n_fail = 0;
  logic [NS-1:0] m_flag = '0;
  logic [NS-1:0] m_en = '0;
  logic          m_sum = 1'b0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  irq_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .src_i(src_i), .irq_no(irq_no)
  );

  function automatic logic m_irq_n();
    return ~|(m_flag & m_en);
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic model(logic [NS-1:0] s, logic w, logic [AW-1:0] a, logic [7:0] d);
    logic [NS-1:0] f, e;
    f = m_flag;
    if (w && a == A_STAT) f = f & ~d[NS-1:0];
    f = f | s;
    e = (w && a == A_EN) ? d[NS-1:0] : m_en;
    m_sum = (m_sum & ~(w && a == A_STAT && d[7])) | (|(f & e));
    m_flag = f;
    m_en = e;
  endtask

  // drive at negedge, one clock, then settle at the next negedge
  task automatic step(logic [NS-1:0] s, logic w, logic [AW-1:0] a, logic [7:0] d);
    src_i = s; wr_i = w; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    model(s, w, a, d);
    @(negedge clk_i);
    src_i = '0; wr_i = 1'b0;
  endtask

  task automatic verify(string tag);
    check({tag, " irq"}, {7'd0, irq_no}, {7'd0, m_irq_n()});
    addr_i = A_STAT; #1;
    check({tag, " stat"}, rdata_o, {m_sum, m_flag});
    addr_i = A_EN; #1;
    check({tag, " en"}, rdata_o, {1'b0, m_en});
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h1, 8'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    repeat (3) @(negedge clk_i);
    addr_i = A_STAT; #1; check("R1 stat in reset", rdata_o, 8'h00);
    addr_i = A_EN;   #1; check("R1 en in reset", rdata_o, 8'h00);
    check("R1 irq in reset", {7'd0, irq_no}, 8'h01);
    rst_ni = 1'b1;
    @(negedge clk_i);
    verify("R1 after release");

    // R2: flag latches while disabled, no request
    step(7'b0000100, 1'b0, A_STAT, 8'h00);
    verify("R2 disabled latch");
    // R6: enabling raises the request, R7 summary follows
    step('0, 1'b1, A_EN, 8'h04);
    verify("R6 enable raises");
    check("R7 summary set", {7'd0, rdata_o[7]}, 8'h00); // addr is EN, bit7 reserved
    addr_i = A_STAT; #1; check("R7 summary bit", {7'd0, rdata_o[7]}, 8'h01);
    // R3: write 0 keeps flag
    step('0, 1'b1, A_STAT, 8'h00);
    verify("R3 write zero");
    // R7: clear summary while pending, stays 1
    step('0, 1'b1, A_STAT, 8'h80);
    verify("R7 summary held");
    // R4: set and clear together
    step(7'b0000100, 1'b1, A_STAT, 8'h04);
    verify("R4 set wins");
    // R6: disable drops request, flag stays
    step('0, 1'b1, A_EN, 8'h00);
    verify("R6 disable drops");
    // R5: reserved enable bit
    step('0, 1'b1, A_EN, 8'hFF);
    verify("R5 reserved bit");
    // R3/R6: clear all flags
    step('0, 1'b1, A_STAT, 8'h7F);
    verify("R3 clear flags");
    // R7: summary clears when nothing pending
    step('0, 1'b1, A_STAT, 8'h80);
    verify("R7 summary clear");
    // R8: other address write ignored, repeated reads change nothing
    step(7'b1000001, 1'b0, A_STAT, 8'h00);
    step('0, 1'b1, 4'd3, 8'h00);
    step('0, 1'b1, 4'd11, 8'h7F);
    addr_i = 4'd3; #1; check("R8 unmapped read", rdata_o, 8'h00);
    repeat (4) begin
      step('0, 1'b0, A_STAT, 8'h00);
      verify("R8 read no effect");
    end

    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [NS-1:0] s;
      logic [AW-1:0] a;
      logic [2:0]    pick;
      s = (($urandom % 4) == 0) ? NS'($urandom) : '0;
      pick = 3'($urandom);
      a = (pick < 3) ? A_STAT : (pick < 5) ? A_EN : AW'($urandom);
      step(s, ($urandom % 3) == 0, a, 8'($urandom));
      verify("R6 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule